// File: doc/BRIEF.md
# Framed Tap Statistics Collector

This block watches one tapped stream, either an event stream taken from a dataflow edge or the occupancy value of an input queue. It folds that stream into a fixed-length window of clock cycles, called a frame, and at the end of each frame it emits one summary record on a valid/ready output. A monitor that reads these records sees how performance changes over time, but it does not have to receive every event.

Each record carries one metric, and a select input chooses which one: a count with a sum, a sum of squares, a minimum, a maximum, an eight-bin histogram or an outlier count. Software derives the mean and the spread from the count, the sum and the sum of squares. The frame length can be changed while the block runs. Longer frames give coarser time resolution and need less interconnect bandwidth. Every record carries a frame sequence number. When the reader stalls, the block keeps the pending record and counts the frames it loses while it waits.

Top module: `ftap_collector`

## Requirements
- R1: A frame lasts `frame_len` clock cycles, and a value of 0 is treated as 1. Frames follow one another with no gap from the first cycle after reset. A frame's record shows on `rec_valid` in the cycle after the frame's last cycle.
- R2: `frame_len` and `stat_sel` are sampled during reset and on each frame's last cycle. The sampled values apply to the next frame. A change made partway through a frame does not alter that frame.
- R3: `rec_count` is the number of cycles in the frame with `tap_valid` high. With select 0, `rec_value` is the sum of the tapped values.
- R4: With select 1, `rec_value` is the sum of the squares of the tapped values.
- R5: Select 2 reports the smallest value and select 3 the largest. `rec_range_ok` is 1 when the frame holds at least one sample. A frame with no samples reports count 0 and `rec_range_ok` 0.
- R6: With select 4, `rec_hist` holds 8 bins chosen by the top 3 bits of the value. Bin i sits at bits [8i+7:8i]. Each bin saturates at 255, and `rec_value` is 0. With any other select, `rec_hist` is 0.
- R7: With select 5, `rec_value` counts the samples strictly greater than `out_thr`.
- R8: While `rec_valid` is high and `rec_ready` is low, the record and all its fields stay unchanged.
- R9: `rec_seq` numbers the frames from 0 after reset, including frames that are lost. A frame that ends while a record is still pending is lost. `rec_dropped` reports how many frames were lost since the previous record was loaded.
- R10: During reset and after it, `rec_valid` stays 0 until the first frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_valid | input | 1 | Tap sample present this cycle |
| tap_value | input | 8 | Tapped value or queue occupancy |
| frame_len | input | 16 | Frame length in cycles, 0 meaning 1 |
| stat_sel | input | 3 | Metric select, codes 0 to 5 |
| out_thr | input | 8 | Outlier threshold |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Reader accepts record |
| rec_seq | output | 8 | Frame sequence number |
| rec_sel | output | 3 | Metric carried by this record |
| rec_count | output | 16 | Samples in the frame |
| rec_value | output | 32 | Selected scalar metric |
| rec_hist | output | 64 | Histogram bins, bin i at bits [8i+7:8i] |
| rec_range_ok | output | 1 | Frame had samples, so min and max are valid |
| rec_dropped | output | 8 | Frames lost before this record, saturating |

## Verification
The assertions assume that `rec_ready` is a plain level from the reader. They also assume that the tap may change at any cycle and that `frame_len` may change at any cycle, not only at frame boundaries. The bench drives every input on the falling edge, and it changes `frame_len` and `stat_sel` in the middle of a frame on purpose, so that the boundary sampling is exercised. Each scenario starts from its own reset, so frame boundaries fall on cycles known in advance. Stalls are made by holding `rec_ready` low across several whole frames.

// File: rtl/ftap_pkg.sv
package ftap_pkg;
    localparam int VAL_W   = 8;
    localparam int LEN_W   = 16;
    localparam int CNT_W   = LEN_W;
    localparam int SUM_W   = VAL_W + CNT_W;
    localparam int SQ_W    = 2 * VAL_W + CNT_W;
    localparam int NBINS   = 8;
    localparam int BSEL_W  = $clog2(NBINS);
    localparam int BIN_W   = 8;
    localparam int HIST_W  = NBINS * BIN_W;
    localparam int SEQ_W   = 8;
    localparam int DROP_W  = 8;
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_SUM   = 3'd0,
        SEL_SQSUM = 3'd1,
        SEL_MIN   = 3'd2,
        SEL_MAX   = 3'd3,
        SEL_HIST  = 3'd4,
        SEL_OUTL  = 3'd5
    } stat_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [SUM_W-1:0] sum;
        logic [SQ_W-1:0]  sq;
        logic [VAL_W-1:0] vmin;
        logic [VAL_W-1:0] vmax;
        logic [CNT_W-1:0] outl;
    } tap_stats_t;

    function automatic tap_stats_t stats_init();
        tap_stats_t s;
        s.count = '0;
        s.sum   = '0;
        s.sq    = '0;
        s.vmin  = '1;
        s.vmax  = '0;
        s.outl  = '0;
        return s;
    endfunction

    function automatic logic [BIN_W-1:0] bin_bump(input logic [BIN_W-1:0] b);
        return (&b) ? b : b + BIN_W'(1);
    endfunction
endpackage

// File: rtl/ftap_frame_timer.sv
module ftap_frame_timer
    import ftap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [SEL_W-1:0] stat_sel,
    output logic             last,
    output stat_sel_e        cur_sel
);
    logic [LEN_W-1:0] cyc;
    logic [LEN_W-1:0] cur_len;
    logic [LEN_W-1:0] eff_len;

    assign eff_len = (frame_len == '0) ? LEN_W'(1) : frame_len;
    assign last    = (cyc == cur_len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst || last) begin
            cyc     <= '0;
            cur_len <= eff_len;
            cur_sel <= stat_sel_e'(stat_sel);
        end else begin
            cyc     <= cyc + LEN_W'(1);
        end
    end

    // R1
    cyc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cyc < cur_len);

    // R2
    len_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(cur_len) && $stable(cur_sel));
endmodule

// File: rtl/ftap_accum.sv
module ftap_accum
    import ftap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tap_valid,
    input  logic [VAL_W-1:0] tap_value,
    input  logic [VAL_W-1:0] out_thr,
    input  logic             last,
    output tap_stats_t       upd
);
    tap_stats_t acc;

    always_comb begin
        upd = acc;
        if (tap_valid) begin
            upd.count = acc.count + CNT_W'(1);
            upd.sum   = acc.sum + SUM_W'(tap_value);
            upd.sq    = acc.sq + SQ_W'(tap_value) * SQ_W'(tap_value);
            if (tap_value < acc.vmin) upd.vmin = tap_value;
            if (tap_value > acc.vmax) upd.vmax = tap_value;
            if (tap_value > out_thr)  upd.outl = acc.outl + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || last) acc <= stats_init();
        else             acc <= upd;
    end

    // R5
    range_order_chk: assert property (@(posedge clk) disable iff (rst)
        (acc.count != '0) |-> (acc.vmin <= acc.vmax));

    // R7
    outl_bound_chk: assert property (@(posedge clk) disable iff (rst)
        acc.outl <= acc.count);
endmodule

// File: rtl/ftap_histogram.sv
module ftap_histogram
    import ftap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tap_valid,
    input  logic [VAL_W-1:0]  tap_value,
    input  logic              last,
    output logic [HIST_W-1:0] hist_upd
);
    logic [BSEL_W-1:0] bin_idx;
    assign bin_idx = tap_value[VAL_W-1 -: BSEL_W];

    for (genvar b = 0; b < NBINS; b++) begin : g_bin
        logic [BIN_W-1:0] cnt;
        logic [BIN_W-1:0] nxt;

        assign nxt = (tap_valid && bin_idx == BSEL_W'(b)) ? bin_bump(cnt) : cnt;
        assign hist_upd[b*BIN_W +: BIN_W] = nxt;

        always_ff @(posedge clk) begin
            if (rst || last) cnt <= '0;
            else             cnt <= nxt;
        end

        // R6
        bin_sat_chk: assert property (@(posedge clk) disable iff (rst)
            (&cnt) && !last |=> (&cnt));
    end
endmodule

// File: rtl/ftap_collector.sv
module ftap_collector
    import ftap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tap_valid,
    input  logic [7:0]        tap_value,
    input  logic [15:0]       frame_len,
    input  logic [2:0]        stat_sel,
    input  logic [7:0]        out_thr,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [7:0]        rec_seq,
    output logic [2:0]        rec_sel,
    output logic [15:0]       rec_count,
    output logic [31:0]       rec_value,
    output logic [63:0]       rec_hist,
    output logic              rec_range_ok,
    output logic [7:0]        rec_dropped
);
    logic              last;
    stat_sel_e         cur_sel;
    tap_stats_t        upd;
    logic [HIST_W-1:0] hist_upd;
    logic [SQ_W-1:0]   pick_value;
    logic [HIST_W-1:0] pick_hist;
    logic [SEQ_W-1:0]  seq_ctr;
    logic [DROP_W-1:0] drop_ctr;
    logic              slot_free;

    ftap_frame_timer u_timer (
        .clk(clk), .rst(rst), .frame_len(frame_len), .stat_sel(stat_sel),
        .last(last), .cur_sel(cur_sel)
    );

    ftap_accum u_accum (
        .clk(clk), .rst(rst), .tap_valid(tap_valid), .tap_value(tap_value),
        .out_thr(out_thr), .last(last), .upd(upd)
    );

    ftap_histogram u_hist (
        .clk(clk), .rst(rst), .tap_valid(tap_valid), .tap_value(tap_value),
        .last(last), .hist_upd(hist_upd)
    );

    always_comb begin
        pick_value = '0;
        pick_hist  = '0;
        case (cur_sel)
            SEL_SUM:   pick_value = SQ_W'(upd.sum);
            SEL_SQSUM: pick_value = upd.sq;
            SEL_MIN:   pick_value = SQ_W'(upd.vmin);
            SEL_MAX:   pick_value = SQ_W'(upd.vmax);
            SEL_HIST:  pick_hist  = hist_upd;
            SEL_OUTL:  pick_value = SQ_W'(upd.outl);
            default:   pick_value = '0;
        endcase
    end

    assign slot_free = !rec_valid || rec_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid    <= 1'b0;
            rec_seq      <= '0;
            rec_sel      <= '0;
            rec_count    <= '0;
            rec_value    <= '0;
            rec_hist     <= '0;
            rec_range_ok <= 1'b0;
            rec_dropped  <= '0;
            seq_ctr      <= '0;
            drop_ctr     <= '0;
        end else begin
            if (rec_valid && rec_ready) rec_valid <= 1'b0;
            if (last) begin
                seq_ctr <= seq_ctr + SEQ_W'(1);
                if (slot_free) begin
                    rec_valid    <= 1'b1;
                    rec_seq      <= seq_ctr;
                    rec_sel      <= cur_sel;
                    rec_count    <= upd.count;
                    rec_value    <= pick_value;
                    rec_hist     <= pick_hist;
                    rec_range_ok <= (upd.count != '0);
                    rec_dropped  <= drop_ctr;
                    drop_ctr     <= '0;
                end else if (!(&drop_ctr)) begin
                    drop_ctr <= drop_ctr + DROP_W'(1);
                end
            end
        end
    end

    // R8
    rec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_seq) && $stable(rec_value)
            && $stable(rec_count) && $stable(rec_hist) && $stable(rec_dropped));

    // R9
    drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (drop_ctr != '0 && drop_ctr != $past(drop_ctr)) |-> $past(rec_valid && !rec_ready));

    // R5
    range_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_range_ok == (rec_count != '0)));
endmodule

// File: tb/ftap_collector_test.sv
module ftap_collector_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tap_valid = 1'b0;
    logic [7:0]  tap_value = '0;
    logic [15:0] frame_len = 16'd4;
    logic [2:0]  stat_sel = '0;
    logic [7:0]  out_thr = 8'd100;
    logic        rec_ready = 1'b1;
    logic        rec_valid;
    logic [7:0]  rec_seq;
    logic [2:0]  rec_sel;
    logic [15:0] rec_count;
    logic [31:0] rec_value;
    logic [63:0] rec_hist;
    logic        rec_range_ok;
    logic [7:0]  rec_dropped;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ftap_collector uut (
        .clk(clk), .rst(rst), .tap_valid(tap_valid), .tap_value(tap_value),
        .frame_len(frame_len), .stat_sel(stat_sel), .out_thr(out_thr),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_seq(rec_seq),
        .rec_sel(rec_sel), .rec_count(rec_count), .rec_value(rec_value),
        .rec_hist(rec_hist), .rec_range_ok(rec_range_ok), .rec_dropped(rec_dropped)
    );

    task automatic chk(input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic start(input int len, input int sel);
        @(negedge clk);
        rst = 1'b1;
        frame_len = 16'(len);
        stat_sel = 3'(sel);
        tap_valid = 1'b0;
        rec_ready = 1'b1;
        @(negedge clk);
    endtask

    task automatic drive(input bit v, input int val);
        @(negedge clk);
        rst = 1'b0;
        tap_valid = v;
        tap_value = 8'(val);
    endtask

    task automatic settle();
        @(negedge clk);
        tap_valid = 1'b0;
    endtask

    task automatic t_reset();
        start(4, 0);
        chk("R10", "valid in reset", rec_valid, 0);
        drive(0, 0);
        drive(0, 0);
        chk("R10", "valid mid frame", rec_valid, 0);
    endtask

    task automatic t_sum();
        start(4, 0);
        drive(1, 3); drive(1, 5); drive(0, 0); drive(1, 7);
        settle();
        chk("R1", "valid after frame", rec_valid, 1);
        chk("R3", "count", rec_count, 3);
        chk("R3", "sum", rec_value, 15);
        chk("R6", "hist zero when not selected", rec_hist, 0);
        chk("R9", "first seq", rec_seq, 0);
    endtask

    task automatic t_sq();
        start(4, 1);
        drive(1, 1); drive(1, 2); drive(1, 3); drive(1, 4);
        settle();
        chk("R4", "sum of squares", rec_value, 30);
        chk("R3", "count", rec_count, 4);
    endtask

    task automatic t_minmax();
        start(4, 2);
        drive(1, 9);
        stat_sel = 3'd3;
        drive(1, 2); drive(1, 200); drive(1, 50);
        settle();
        chk("R5", "min", rec_value, 2);
        chk("R2", "select kept for frame", rec_sel, 2);
        chk("R5", "range ok", rec_range_ok, 1);
        drive(1, 9); drive(1, 250); drive(1, 4);
        settle();
        chk("R5", "max", rec_value, 250);
        chk("R2", "new select next frame", rec_sel, 3);
        chk("R9", "second seq", rec_seq, 1);
    endtask

    task automatic t_empty();
        start(3, 2);
        drive(0, 0); drive(0, 0); drive(0, 0);
        settle();
        chk("R5", "empty valid", rec_valid, 1);
        chk("R5", "empty count", rec_count, 0);
        chk("R5", "empty range flag", rec_range_ok, 0);
    endtask

    task automatic t_len_zero();
        start(0, 0);
        drive(1, 9);
        settle();
        chk("R1", "len0 record", rec_valid, 1);
        chk("R1", "len0 sum", rec_value, 9);
        drive(1, 4);
        settle();
        chk("R1", "len0 second sum", rec_value, 4);
        chk("R1", "len0 second seq", rec_seq, 2);
    endtask

    task automatic t_hist();
        start(4, 4);
        drive(1, 'h10); drive(1, 'h30); drive(1, 'h35); drive(1, 'hE0);
        settle();
        chk("R6", "bins", rec_hist, 64'h0100_0000_0000_0201);
        chk("R6", "value zero", rec_value, 0);
    endtask

    task automatic t_hist_sat();
        start(300, 4);
        for (int i = 0; i < 300; i++) drive(1, 'h20);
        settle();
        chk("R6", "saturated bin", rec_hist, 64'h0000_0000_0000_FF00);
        chk("R3", "count 300", rec_count, 300);
    endtask

    task automatic t_outl();
        start(4, 5);
        out_thr = 8'd100;
        drive(1, 100); drive(1, 101); drive(1, 255); drive(1, 5);
        settle();
        chk("R7", "outliers", rec_value, 2);
    endtask

    task automatic t_len_change();
        start(4, 0);
        drive(1, 1);
        frame_len = 16'd6;
        drive(1, 1); drive(1, 1); drive(1, 1);
        settle();
        chk("R2", "old length kept", rec_count, 4);
        drive(1, 1); drive(1, 1); drive(1, 1); drive(1, 1);
        chk("R2", "no early boundary", rec_valid, 0);
        drive(1, 1);
        settle();
        chk("R2", "new length applied", rec_valid, 1);
        chk("R2", "new length count", rec_count, 5);
    endtask

    task automatic t_backpressure();
        start(2, 0);
        rec_ready = 1'b0;
        for (int i = 0; i < 5; i++) drive(1, 1);
        chk("R8", "held seq", rec_seq, 0);
        drive(1, 1);
        drive(1, 1);
        rec_ready = 1'b1;
        chk("R8", "held valid", rec_valid, 1);
        chk("R8", "held sum", rec_value, 2);
        chk("R9", "held dropped", rec_dropped, 0);
        drive(1, 1);
        settle();
        chk("R9", "seq after loss", rec_seq, 3);
        chk("R9", "dropped count", rec_dropped, 2);
        chk("R3", "sum after loss", rec_value, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sum();
        t_sq();
        t_minmax();
        t_empty();
        t_len_zero();
        t_hist();
        t_hist_sat();
        t_outl();
        t_len_change();
        t_backpressure();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule